// File: doc/BRIEF.md
# Byte-Read Word-Write On-Chip Memory

This block is a single-clock memory with two ports of different widths over one storage array. The write side stores whole 32-bit words, one per cycle. The read side returns one 8-bit byte per cycle. A producer that works in words can use it to fill a buffer, and a consumer that works in bytes can then drain that buffer.

The read address counts bytes, so it is two bits wider than the word address on the write side. Its upper bits pick the word and its two lowest bits pick the byte lane within that word. Lanes are little-endian. One parameter sets the size: the width of the byte address. The word-address width and the word count are derived from it.

Every input is registered on the rising clock edge. The read byte is then formed combinationally from the registered read address, so it is valid in the cycle after the address is presented. A write presented in a cycle reaches the array on the following edge. As a result, a read of the same word in that same cycle still returns the earlier contents. Memory contents are not initialised. Reset only clears the pending write strobe.

Top module: `asym_ram_top`

## Requirements
- R1: The write port takes a 32-bit word at a word address `RD_ADDR_W-2` bits wide. The read port returns 8 bits at a byte address `RD_ADDR_W` bits wide, over the same storage.
- R2: A read address presented before a rising edge produces its byte on `rdData` throughout the following cycle. That is one cycle of latency with no output register.
- R3: Byte address bits [1:0] select the lane, little-endian. Lane 0 is write-data bits 7:0, lane 1 is 15:8, lane 2 is 23:16 and lane 3 is 31:24. Bits above [1:0] select the word.
- R4: When `wrEn` is low in a cycle, no stored word changes, whatever `wrAddr` and `wrData` carry.
- R5: A word written in cycle n can be read back starting with a read address presented in cycle n+1.
- R6: When a read and a write address the same word in the same cycle, the read returns the word's previous contents (read-before-write).
- R7: A write requested while `rst` is high is discarded. In the first cycle after reset, no write strobe is active.
- R8: All 2**(`RD_ADDR_W`-2) words are individually addressable, and each holds its value independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the write strobe |
| wrEn | input | 1 | Write request for the current cycle |
| wrAddr | input | RD_ADDR_W-2 | Word address of the write |
| wrData | input | 32 | Word to store |
| rdAddr | input | RD_ADDR_W | Byte address of the read |
| rdData | output | 8 | Byte selected by the registered read address |

## Verification
The assertions assume a few things about the inputs. The clock runs continuously, `rst` is held for at least one edge, and every address presented lies inside the array. With the default parameter every address value is in range, so the last assumption always holds. The stimulus writes every word before any byte of it is compared, because the unreset array would otherwise hold unknown values. It never expects a defined byte from a word that has not been written. All inputs change only on the falling edge, which keeps them well away from the capturing edge.

// File: rtl/asym_ram_pkg.sv
package asym_ram_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int LANES      = WORD_W / BYTE_W;
  localparam int LANE_SEL_W = $clog2(LANES);

  typedef struct packed {
    logic                  wrStb;
    logic [LANE_SEL_W-1:0] laneSel;
  } ramStrobe_t;
endpackage

// File: rtl/asym_ram_ctrl.sv
module asym_ram_ctrl
  import asym_ram_pkg::*;
#(
  parameter int RD_ADDR_W = 10,
  localparam int WR_ADDR_W = RD_ADDR_W - LANE_SEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [WR_ADDR_W-1:0] wrAddr,
  input  logic [RD_ADDR_W-1:0] rdAddr,
  output ramStrobe_t           strobe,
  output logic [WR_ADDR_W-1:0] wrWordQ,
  output logic [WR_ADDR_W-1:0] rdWordQ
);
  logic                  wrEnQ;
  logic [LANE_SEL_W-1:0] laneSelQ;

  always_ff @(posedge clk) begin
    if (rst) wrEnQ <= 1'b0;
    else     wrEnQ <= wrEn;
  end

  always_ff @(posedge clk) begin
    wrWordQ  <= wrAddr;
    rdWordQ  <= rdAddr[RD_ADDR_W-1:LANE_SEL_W];
    laneSelQ <= rdAddr[LANE_SEL_W-1:0];
  end

  always_comb begin
    strobe.wrStb   = wrEnQ;
    strobe.laneSel = laneSelQ;
  end

  // R2
  rd_capture_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> {rdWordQ, strobe.laneSel} == $past(rdAddr));

  // R7
  wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !strobe.wrStb);
endmodule

// File: rtl/asym_ram_dp.sv
module asym_ram_dp
  import asym_ram_pkg::*;
#(
  parameter int WR_ADDR_W = 8,
  localparam int DEPTH = 1 << WR_ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ramStrobe_t           strobe,
  input  logic [WR_ADDR_W-1:0] wrWordQ,
  input  logic [WR_ADDR_W-1:0] rdWordQ,
  input  logic [WORD_W-1:0]    wrData,
  output logic [BYTE_W-1:0]    rdData
);
  logic [WORD_W-1:0] storage [DEPTH];
  logic [WORD_W-1:0] wrDataQ;
  logic [WORD_W-1:0] rdWord;
  logic [BYTE_W-1:0] laneBytes [LANES];

  always_ff @(posedge clk) wrDataQ <= wrData;

  always_ff @(posedge clk) begin
    if (strobe.wrStb) storage[wrWordQ] <= wrDataQ;
  end

  assign rdWord = storage[rdWordQ];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneBytes[g] = rdWord[g*BYTE_W +: BYTE_W];
  end

  assign rdData = laneBytes[strobe.laneSel];

  // R4
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrStb |=> storage[$past(wrWordQ)] == $past(storage[wrWordQ]));

  // R5
  wr_land_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.wrStb |=> storage[$past(wrWordQ)] == $past(wrDataQ));
endmodule

// File: rtl/asym_ram_top.sv
module asym_ram_top
  import asym_ram_pkg::*;
#(
  parameter int RD_ADDR_W = 10,
  localparam int WR_ADDR_W = RD_ADDR_W - LANE_SEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [WR_ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [RD_ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0]    rdData
);
  ramStrobe_t           strobe;
  logic [WR_ADDR_W-1:0] wrWordQ;
  logic [WR_ADDR_W-1:0] rdWordQ;

  asym_ram_ctrl #(.RD_ADDR_W(RD_ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .strobe(strobe), .wrWordQ(wrWordQ), .rdWordQ(rdWordQ)
  );

  asym_ram_dp #(.WR_ADDR_W(WR_ADDR_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .wrWordQ(wrWordQ),
    .rdWordQ(rdWordQ), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/asym_ram_top_tb_top.sv
`timescale 1ns/1ps
module asym_ram_top_tb_top;
  localparam int RA = 10;
  localparam int WA = RA - 2;
  localparam int NWORDS = 1 << WA;
  localparam int NBYTES = 1 << RA;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic [WA-1:0] wrAddr = '0;
  logic [31:0]   wrData = '0;
  logic [RA-1:0] rdAddr = '0;
  logic [7:0]    rdData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    int         addr;
    logic [7:0] val;
    string      tag;
  } expItem_t;

  expItem_t   expQ [$];
  logic [7:0] refMem [NBYTES];

  asym_ram_top #(.RD_ADDR_W(RA)) dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] pat(input int w, input int salt);
    return (w * 32'h0103_0507) ^ 32'hC3A5_5A3C ^ (salt * 32'h1111_0F0F);
  endfunction

  task automatic drive(input logic we, input int wa, input logic [31:0] wd,
                       input int ra, input bit chk, input string tag);
    @(negedge clk);
    wrEn = we; wrAddr = wa[WA-1:0]; wrData = wd; rdAddr = ra[RA-1:0];
    if (chk) begin
      expItem_t e;
      e.due = cyc + 1; e.addr = ra; e.val = refMem[ra]; e.tag = tag;
      expQ.push_back(e);
    end
    if (we) for (int b = 0; b < 4; b++) refMem[wa*4+b] = wd[b*8 +: 8];
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      while (expQ.size() > 0 && expQ[0].due == cyc) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (rdData !== e.val) begin
          errors++;
          $display("FAIL %s: byte addr %0d actual %h expected %h", e.tag, e.addr, rdData, e.val);
        end
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8 / R1: fill every word
    for (int w = 0; w < NWORDS; w++) drive(1'b1, w, pat(w, 0), 0, 1'b0, "");

    // R1 R3 R8 R2: sweep every byte, lane order little-endian
    for (int a = 0; a < NBYTES; a++) drive(1'b0, 0, 32'h0, a, 1'b1, "R3_R8_sweep");

    // R3: known word, explicit lane positions
    drive(1'b1, 7, 32'h4433_2211, 0, 1'b0, "");
    for (int l = 0; l < 4; l++) drive(1'b0, 0, 32'h0, 7*4+l, 1'b1, "R3_lane");

    // R4: write disabled while address and data toggle
    drive(1'b0, 5, 32'hFFFF_FFFF, 0, 1'b0, "");
    drive(1'b0, 5, 32'h0000_0000, 0, 1'b0, "");
    for (int l = 0; l < 4; l++) drive(1'b0, 5, 32'hA5A5_A5A5, 5*4+l, 1'b1, "R4_nowrite");

    // R5: write then read the following cycle
    drive(1'b1, 9, 32'hCAFE_F00D, 0, 1'b0, "");
    drive(1'b0, 0, 32'h0, 9*4+2, 1'b1, "R5_next");

    // R6: same word read and written in one cycle returns old contents
    drive(1'b1, 12, 32'h1234_5678, 12*4+1, 1'b1, "R6_old");
    drive(1'b0, 0, 32'h0, 12*4+1, 1'b1, "R6_new");

    // R5 R6: back-to-back writes to one word with reads trailing
    drive(1'b1, 30, 32'h0A0B_0C0D, 30*4+3, 1'b1, "R6_chain");
    drive(1'b1, 30, 32'h1A1B_1C1D, 30*4+3, 1'b1, "R6_chain");
    drive(1'b1, 31, 32'h2A2B_2C2D, 30*4+0, 1'b1, "R5_chain");
    drive(1'b0, 0, 32'h0, 31*4+2, 1'b1, "R5_chain");

    // R8: extreme addresses are independent
    drive(1'b1, NWORDS-1, 32'h8899_AABB, 0, 1'b0, "");
    drive(1'b0, 0, 32'h0, NBYTES-1, 1'b1, "R8_top");
    drive(1'b0, 0, 32'h0, 0, 1'b1, "R8_bottom");

    // R7: write requested during reset is discarded
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b1; wrAddr = 20; wrData = 32'hDEAD_BEEF;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; wrEn = 1'b0;
    drive(1'b0, 0, 32'h0, 20*4+0, 1'b1, "R7_reset_drop");
    drive(1'b0, 0, 32'h0, 20*4+3, 1'b1, "R7_reset_drop");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: pending reads actual %0d expected 0", expQ.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule